// File: doc/BRIEF.md
# Single-Cycle Processor Datapath

This block is the 32-bit execution path of a load/store processor that retires one instruction per clock. It owns the program counter, a 32-entry general register file, the immediate sign extender, the ALU with its operand and write-back multiplexers, and the next-PC selection for sequential, branch and jump flow. All control decisions come in as plain signals from a decoder outside the block. Instruction and data memories are also outside: the block presents the PC to fetch, takes the instruction word back, and drives address and store data towards data memory while accepting load data.

Within a single cycle the instruction selects its source registers, the ALU forms a result from two registers or from a register and the immediate, the result or the load data is written back, and the PC moves to its next value on the rising edge. The ALU code is a 3-bit field. Its top bit inverts the second operand and supplies the carry-in, which turns the adder into a subtractor. Its low two bits pick the logic, arithmetic or compare output.

Top module: `sc_datapath`

## Requirements
- R1: While `rst` is high at a rising edge the PC becomes 0. After reset the PC reads 0 until the next rising edge.
- R2: When neither `br_take` nor `jmp` is high, the PC becomes PC+4 on each rising edge.
- R3: When `br_take` is high and `jmp` is low, the next PC is PC+4 plus the sign-extended `instr[15:0]` shifted left by two.
- R4: When `jmp` is high, the next PC is the upper four bits of PC+4, then `instr[25:0]`, then two zero bits. This holds whatever the value of `br_take`.
- R5: Register read port A is addressed by `instr[25:21]` and read port B by `instr[20:16]`. Both reads are combinational. A write takes effect at the rising edge.
- R6: Register 0 always reads as zero, and a write to it has no effect.
- R7: The destination register is `instr[20:16]` when `dst_sel` is 0 and `instr[15:11]` when `dst_sel` is 1.
- R8: The second ALU operand is read port B when `alu_imm` is 0. When `alu_imm` is 1 it is `instr[15:0]` sign-extended to 32 bits.
- R9: `alu_op` selects the ALU function:
  - 000: A AND B
  - 001: A OR B
  - 010: A+B
  - 100: A AND NOT B
  - 101: A OR NOT B
  - 110: A−B
  - 111: the sign bit of A−B, zero-extended.
- R10: `zero` is 1 exactly when the ALU result is all zeros.
- R11: The value written back is the ALU result when `mem_to_reg` is 0 and `dmem_rdata` when it is 1.
- R12: With `reg_wr` low, no register changes.
- R13: `dmem_addr` carries the ALU result and `dmem_wdata` carries read port B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write enable for the register file |
| dst_sel | input | 1 | Destination field select: 0 picks bits 20:16, 1 picks bits 15:11 |
| alu_imm | input | 1 | Second ALU operand select: 1 picks the immediate |
| mem_to_reg | input | 1 | Write-back select: 1 picks load data |
| br_take | input | 1 | Take the PC-relative branch target |
| jmp | input | 1 | Take the jump target (highest priority) |
| alu_op | input | 3 | ALU function code |
| instr | input | 32 | Instruction word fetched at `pc` |
| pc | output | 32 | Program counter |
| dmem_addr | output | 32 | Data memory address (ALU result) |
| dmem_wdata | output | 32 | Data memory store data (read port B) |
| dmem_rdata | input | 32 | Data memory load data |
| zero | output | 1 | ALU result is zero |

## Verification
The hardest case to reach is a jump whose kept upper four PC bits are nonzero. Reset leaves those bits at zero. A jump cannot change them. A single branch moves the PC by at most about 128 KiB. The bench therefore takes 2048 maximal forward branches in a row, which carries the PC across the 256 MiB boundary. It then issues a jump and checks that the upper nibble survives while the lower 28 bits come from the instruction. Register contents are never read directly. Each one is written through the load or immediate path and brought back out through `dmem_wdata` or `dmem_addr`.

// File: rtl/scdp_pkg.sv
`timescale 1ns/1ps
package scdp_pkg;

  // ALU function codes (bit 2 inverts operand B and supplies carry-in)
  typedef enum logic [2:0] {
    FN_AND  = 3'b000,
    FN_OR   = 3'b001,
    FN_ADD  = 3'b010,
    FN_RSV  = 3'b011,
    FN_ANDN = 3'b100,
    FN_ORN  = 3'b101,
    FN_SUB  = 3'b110,
    FN_SLT  = 3'b111
  } alu_fn_e;

  // output selection from the low two bits of the function code
  localparam logic [1:0] SEL_AND = 2'b00;
  localparam logic [1:0] SEL_OR  = 2'b01;
  localparam logic [1:0] SEL_SUM = 2'b10;
  localparam logic [1:0] SEL_CMP = 2'b11;

  // instruction field geometry
  localparam int unsigned INSN_W   = 32;
  localparam int unsigned RIDX_W   = 5;
  localparam int unsigned SRC_A_LO = 21;
  localparam int unsigned SRC_B_LO = 16;
  localparam int unsigned DST_R_LO = 11;
  localparam int unsigned IMM_W    = 16;
  localparam int unsigned JIDX_W   = 26;
  localparam int unsigned PAGE_W   = 4;

endpackage

// File: rtl/scdp_regfile.sv
`timescale 1ns/1ps
module scdp_regfile #(
  parameter int unsigned W        = 32,
  parameter int unsigned AW       = 5,
  parameter bit          ZERO_REG = 1'b1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra_a,
  output logic [W-1:0]  rd_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_b
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] store [DEPTH];
  logic         we_eff;

  generate
    if (ZERO_REG) begin : g_hardzero
      assign we_eff = we && (wa != '0);
      assign rd_a   = (ra_a == '0) ? '0 : store[ra_a];
      assign rd_b   = (ra_b == '0) ? '0 : store[ra_b];
    end else begin : g_plain
      assign we_eff = we;
      assign rd_a   = store[ra_a];
      assign rd_b   = store[ra_b];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (we_eff) begin
      store[wa] <= wd;
    end
  end

endmodule

// File: rtl/scdp_alu.sv
`timescale 1ns/1ps
module scdp_alu
  import scdp_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [2:0]   fn,
  output logic [W-1:0] res,
  output logic         is_zero
);

  logic         inv_b;
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;

  assign inv_b = fn[2];
  assign b_eff = inv_b ? ~opb : opb;
  assign sum   = opa + b_eff + {{(W-1){1'b0}}, inv_b};

  always_comb begin
    unique case (fn[1:0])
      SEL_AND: res = opa & b_eff;
      SEL_OR:  res = opa | b_eff;
      SEL_SUM: res = sum;
      default: res = {{(W-1){1'b0}}, sum[W-1]};
    endcase
  end

  assign is_zero = (res == '0);

endmodule

// File: rtl/scdp_nextpc.sv
`timescale 1ns/1ps
module scdp_nextpc
  import scdp_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]      pc_cur,
  input  logic [W-1:0]      simm,
  input  logic [JIDX_W-1:0] jidx,
  input  logic              br_take,
  input  logic              jmp,
  output logic [W-1:0]      pc_seq,
  output logic [W-1:0]      pc_nxt
);

  localparam logic [W-1:0] STEP = W'(4);

  logic [W-1:0] br_tgt;
  logic [W-1:0] jmp_tgt;

  assign pc_seq  = pc_cur + STEP;
  assign br_tgt  = pc_seq + {simm[W-3:0], 2'b00};
  assign jmp_tgt = {pc_seq[W-1:W-PAGE_W], jidx, 2'b00};

  always_comb begin
    if (jmp) begin
      pc_nxt = jmp_tgt;
    end else if (br_take) begin
      pc_nxt = br_tgt;
    end else begin
      pc_nxt = pc_seq;
    end
  end

endmodule

// File: rtl/sc_datapath.sv
`timescale 1ns/1ps
module sc_datapath
  import scdp_pkg::*;
#(
  parameter int unsigned    XLEN     = 32,
  parameter logic [31:0]    RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr,
  input  logic            dst_sel,
  input  logic            alu_imm,
  input  logic            mem_to_reg,
  input  logic            br_take,
  input  logic            jmp,
  input  logic [2:0]      alu_op,
  input  logic [31:0]     instr,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic            zero
);

  localparam int unsigned SX_W = XLEN - IMM_W;

  logic [RIDX_W-1:0] src_a_idx;
  logic [RIDX_W-1:0] src_b_idx;
  logic [RIDX_W-1:0] dst_idx;
  logic [XLEN-1:0]   simm;
  logic [XLEN-1:0]   rs_val;
  logic [XLEN-1:0]   rt_val;
  logic [XLEN-1:0]   alu_b;
  logic [XLEN-1:0]   alu_res;
  logic [XLEN-1:0]   wb_val;
  logic [XLEN-1:0]   pc_seq;
  logic [XLEN-1:0]   pc_nxt;
  logic              unused_opc;

  assign unused_opc = ^instr[INSN_W-1:SRC_A_LO+RIDX_W];

  // field extraction
  assign src_a_idx = instr[SRC_A_LO +: RIDX_W];
  assign src_b_idx = instr[SRC_B_LO +: RIDX_W];
  assign dst_idx   = dst_sel ? instr[DST_R_LO +: RIDX_W] : src_b_idx;
  assign simm      = {{SX_W{instr[IMM_W-1]}}, instr[IMM_W-1:0]};

  scdp_regfile #(
    .W        (XLEN),
    .AW       (RIDX_W),
    .ZERO_REG (1'b1)
  ) u_rf (
    .clk  (clk),
    .we   (reg_wr),
    .wa   (dst_idx),
    .wd   (wb_val),
    .ra_a (src_a_idx),
    .rd_a (rs_val),
    .ra_b (src_b_idx),
    .rd_b (rt_val)
  );

  assign alu_b = alu_imm ? simm : rt_val;

  scdp_alu #(
    .W (XLEN)
  ) u_alu (
    .opa     (rs_val),
    .opb     (alu_b),
    .fn      (alu_op),
    .res     (alu_res),
    .is_zero (zero)
  );

  assign wb_val     = mem_to_reg ? dmem_rdata : alu_res;
  assign dmem_addr  = alu_res;
  assign dmem_wdata = rt_val;

  scdp_nextpc #(
    .W (XLEN)
  ) u_npc (
    .pc_cur  (pc),
    .simm    (simm),
    .jidx    (instr[JIDX_W-1:0]),
    .br_take (br_take),
    .jmp     (jmp),
    .pc_seq  (pc_seq),
    .pc_nxt  (pc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= RESET_PC[XLEN-1:0];
    end else begin
      pc <= pc_nxt;
    end
  end

endmodule

// File: rtl/sc_datapath_chk.sv
`timescale 1ns/1ps
module sc_datapath_chk #(
  parameter int unsigned XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input logic            clk,
  input logic            rst,
  input logic            reg_wr,
  input logic            dst_sel,
  input logic            alu_imm,
  input logic            mem_to_reg,
  input logic            br_take,
  input logic            jmp,
  input logic [2:0]      alu_op,
  input logic [31:0]     instr,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] dmem_addr,
  input logic [XLEN-1:0] dmem_wdata,
  input logic [XLEN-1:0] dmem_rdata,
  input logic            zero
);

  logic [XLEN-1:0] inc_pc;
  logic [XLEN-1:0] off_pc;
  logic            unused_in;

  assign inc_pc    = pc + XLEN'(4);
  assign off_pc    = inc_pc + {{(XLEN-18){instr[15]}}, instr[15:0], 2'b00};
  assign unused_in = ^{reg_wr, dst_sel, alu_imm, mem_to_reg, alu_op, dmem_rdata};

  // R1: first cycle out of reset shows the reset PC
  a_r1_pc_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc == RESET_PC[XLEN-1:0]));

  // R2: sequential flow
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    (!jmp && !br_take) |=> (pc == $past(inc_pc)));

  // R3: taken branch
  a_r3_branch: assert property (@(posedge clk) disable iff (rst)
    (br_take && !jmp) |=> (pc == $past(off_pc)));

  // R4: jump keeps the page bits and word-aligns the index
  a_r4_jump: assert property (@(posedge clk) disable iff (rst)
    jmp |=> ((pc[1:0] == 2'b00)
          && (pc[XLEN-1:28] == $past(inc_pc[XLEN-1:28]))
          && (pc[27:2] == $past(instr[25:0]))));

  // R6: register 0 on read port B
  a_r6_reg0_b: assert property (@(posedge clk) disable iff (rst)
    (instr[20:16] == 5'd0) |-> (dmem_wdata == '0));

  // R10: flag agrees with the result on the address bus
  a_r10_zero_flag: assert property (@(posedge clk) disable iff (rst)
    zero == (dmem_addr == '0));

endmodule

bind sc_datapath sc_datapath_chk #(
  .XLEN     (XLEN),
  .RESET_PC (RESET_PC)
) u_chk (.*);

// File: tb/sc_datapath_test.sv
`timescale 1ns/1ps
module sc_datapath_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr, dst_sel, alu_imm, mem_to_reg, br_take, jmp;
  logic [2:0]  alu_op;
  logic [31:0] instr, dmem_rdata;
  logic [31:0] pc, dmem_addr, dmem_wdata;
  logic        zero;

  int unsigned nvec  = 0;
  int unsigned nfail = 0;
  logic [31:0] exp_pc = 32'h0;

  always #4 clk = ~clk;

  sc_datapath uut (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .dst_sel    (dst_sel),
    .alu_imm    (alu_imm),
    .mem_to_reg (mem_to_reg),
    .br_take    (br_take),
    .jmp        (jmp),
    .alu_op     (alu_op),
    .instr      (instr),
    .pc         (pc),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_rdata (dmem_rdata),
    .zero       (zero)
  );

  function automatic logic [31:0] ity(input logic [4:0] rs, input logic [4:0] rt,
                                      input logic [15:0] imm);
    return {6'b001000, rs, rt, imm};
  endfunction

  function automatic logic [31:0] rty(input logic [4:0] rs, input logic [4:0] rt,
                                      input logic [4:0] rd);
    return {6'b000000, rs, rt, rd, 5'd0, 6'b100000};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    reg_wr = 0; dst_sel = 0; alu_imm = 0; mem_to_reg = 0;
    br_take = 0; jmp = 0; alu_op = 3'b010; instr = 32'h0; dmem_rdata = 32'h0;
  endtask

  // one clock; the expected PC follows from the held inputs (R1..R4)
  task automatic tick();
    logic [31:0] p4, nxt, off;
    string req;
    p4  = exp_pc + 32'd4;
    off = {{14{instr[15]}}, instr[15:0], 2'b00};
    if (rst)          begin nxt = 32'h0;                           req = "R1"; end
    else if (jmp)     begin nxt = {p4[31:28], instr[25:0], 2'b00}; req = "R4"; end
    else if (br_take) begin nxt = p4 + off;                        req = "R3"; end
    else              begin nxt = p4;                              req = "R2"; end
    @(posedge clk);
    @(negedge clk);
    exp_pc = nxt;
    chk(req, "pc", pc, exp_pc);
  endtask

  task automatic put_imm(input logic [4:0] r, input logic [15:0] imm);
    idle(); instr = ity(5'd0, r, imm); alu_imm = 1; reg_wr = 1;
    tick(); idle();
  endtask

  task automatic put_mem(input logic [4:0] r, input logic [31:0] v);
    idle(); instr = ity(5'd0, r, 16'h0); alu_imm = 1; mem_to_reg = 1;
    dmem_rdata = v; reg_wr = 1;
    tick(); idle();
  endtask

  task automatic peek_b(input logic [4:0] r, input string req, input logic [31:0] exp);
    idle(); instr = rty(5'd0, r, 5'd0); #1;
    chk(req, "port B read", dmem_wdata, exp);
    tick();
  endtask

  task automatic peek_a(input logic [4:0] r, input string req, input logic [31:0] exp);
    idle(); instr = ity(r, 5'd0, 16'h0); alu_imm = 1; #1;
    chk(req, "port A read", dmem_addr, exp);
    tick();
  endtask

  task automatic run_alu(input logic [2:0] op, input logic [4:0] rs, input logic [4:0] rt,
                         input logic [31:0] exp, input string req);
    idle(); instr = rty(rs, rt, 5'd0); alu_op = op; #1;
    chk(req, "alu result", dmem_addr, exp);
    chk("R10", "zero flag", {31'd0, zero}, {31'd0, exp == 32'h0});
    tick();
  endtask

  task automatic t_reset();
    rst = 1; idle();
    tick();
    jmp = 1; instr = {6'b000010, 26'h3ABCDEF};
    tick();
    chk("R1", "pc held in reset", pc, 32'h0);
    idle(); rst = 0;
    tick();
    chk("R2", "first step", pc, 32'h4);
  endtask

  task automatic t_regs();
    put_imm(5'd5, 16'h1234);
    put_imm(5'd6, 16'hFFF0);
    peek_b(5'd5, "R5", 32'h0000_1234);
    peek_a(5'd6, "R8", 32'hFFFF_FFF0);
    peek_a(5'd5, "R5", 32'h0000_1234);
    put_imm(5'd0, 16'h0055);
    peek_b(5'd0, "R6", 32'h0);
    peek_a(5'd0, "R6", 32'h0);
    idle(); instr = ity(5'd0, 5'd5, 16'h0007); alu_imm = 1; reg_wr = 0;
    tick();
    peek_b(5'd5, "R12", 32'h0000_1234);
  endtask

  task automatic t_dst();
    put_imm(5'd9, 16'h0011);
    idle(); instr = rty(5'd5, 5'd6, 5'd7); dst_sel = 1; reg_wr = 1;
    tick();
    peek_b(5'd7, "R7", 32'h0000_1224);
    peek_b(5'd6, "R7", 32'hFFFF_FFF0);
    // rd field = 9 inside the immediate, but dst_sel=0 picks rt=8
    idle(); instr = {6'b001000, 5'd5, 5'd8, 16'h4800}; alu_imm = 1; reg_wr = 1;
    tick();
    peek_b(5'd8, "R7", 32'h0000_5A34);
    peek_b(5'd9, "R7", 32'h0000_0011);
  endtask

  task automatic t_mem();
    logic [31:0] a, b;
    a = 32'hF0F0_00FF; b = 32'h0FF0_0F0F;
    put_mem(5'd10, a);
    put_mem(5'd11, b);
    peek_b(5'd10, "R11", a);
    peek_b(5'd11, "R11", b);
    idle(); instr = ity(5'd0, 5'd15, 16'h0042); alu_imm = 1; reg_wr = 1;
    dmem_rdata = 32'hDEAD_BEEF;
    tick();
    peek_b(5'd15, "R11", 32'h0000_0042);
    idle(); instr = ity(5'd5, 5'd6, 16'h0010); alu_imm = 1; #1;
    chk("R13", "address", dmem_addr, 32'h0000_1244);
    chk("R13", "store data", dmem_wdata, 32'hFFFF_FFF0);
    tick();
    idle(); instr = ity(5'd5, 5'd10, 16'hFFFC); alu_imm = 1; #1;
    chk("R13", "negative offset address", dmem_addr, 32'h0000_1230);
    chk("R13", "store data", dmem_wdata, a);
    tick();
  endtask

  task automatic t_alu();
    logic [31:0] a, b;
    a = 32'hF0F0_00FF; b = 32'h0FF0_0F0F;
    run_alu(3'b000, 5'd10, 5'd11, a & b,  "R9");
    run_alu(3'b001, 5'd10, 5'd11, a | b,  "R9");
    run_alu(3'b010, 5'd10, 5'd11, a + b,  "R9");
    run_alu(3'b100, 5'd10, 5'd11, a & ~b, "R9");
    run_alu(3'b101, 5'd10, 5'd11, a | ~b, "R9");
    run_alu(3'b110, 5'd10, 5'd11, a - b,  "R9");
    run_alu(3'b110, 5'd5,  5'd5,  32'h0,  "R10");
    put_imm(5'd12, 16'h0005);
    put_imm(5'd13, 16'h0009);
    put_imm(5'd14, 16'hFFFD);
    run_alu(3'b111, 5'd12, 5'd13, 32'h1, "R9");
    run_alu(3'b111, 5'd13, 5'd12, 32'h0, "R9");
    run_alu(3'b111, 5'd14, 5'd12, 32'h1, "R9");
  endtask

  task automatic t_flow();
    idle(); br_take = 1; instr = ity(5'd0, 5'd0, 16'h0003);
    tick();
    idle(); br_take = 1; instr = ity(5'd0, 5'd0, 16'hFFFE);
    tick();
    idle(); jmp = 1; instr = {6'b000010, 26'h00A_BCDE};
    tick();
    chk("R4", "jump target", pc, {4'h0, 26'h00A_BCDE, 2'b00});
    idle(); jmp = 1; br_take = 1; instr = {6'b000010, 26'h000_1234};
    tick();
    chk("R4", "jump over branch", pc, 32'h0000_48D0);
  endtask

  task automatic t_far();
    idle(); br_take = 1; instr = ity(5'd0, 5'd0, 16'h7FFF);
    for (int i = 0; i < 2048; i++) begin
      tick();
    end
    chk("R3", "upper nibble after far branches", {28'h0, pc[31:28]}, 32'h1);
    idle(); jmp = 1; instr = {6'b000010, 26'h000_0010};
    tick();
    chk("R4", "page kept on jump", pc, 32'h1000_0040);
    idle();
    tick();
  endtask

  initial begin
    rst = 1; idle();
    t_reset();
    t_regs();
    t_dst();
    t_mem();
    t_alu();
    t_flow();
    t_far();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nvec++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule